// File: doc/BRIEF.md
# Multithreaded Latency-Hiding Issue Scheduler

This block picks, on every clock, which of several hardware thread contexts in a single-issue core gets the one issue slot. Each context keeps its own program counter and two flags: one marks a wait on an outstanding long-latency load, the other marks a finished thread. A thread may issue only when it offers an instruction, has no load outstanding and has not finished. Among such threads the grant rotates, so a thread that waits on memory gives its slot to the others. The memory latency is therefore hidden behind useful work rather than shortened.

The issue decision depends only on the current context flags and the per-thread inputs of the same clock. The grant, its thread number and that thread's program counter show up on the outputs in the same cycle. Flag and program-counter updates take effect at the next rising edge. A returning load names its thread through a completion strobe and thread number, and that thread becomes eligible again from the next clock on.

Top module: `mt_issue_sched`

## Requirements
- R1: After reset every context is eligible, and the program counter of thread t starts at t × 0x0400. The rotation pointer starts at the highest thread number, so with all threads offering, thread 0 issues first.
- R2: No more than one thread issues per clock. `issue_vld_o` high implies `avail_i[issue_tid_o]` is high, and `issue_pc_o` is that thread's current program counter.
- R3: When a thread issues with its `load_i` bit high, it is not issued again until `cmpl_vld_i` is high with `cmpl_tid_i` equal to its number. A completion that carries another number leaves it waiting.
- R4: While some threads wait on loads, the block still issues in every clock in which any other thread is eligible.
- R5: Among eligible threads the grant goes to the first one found by searching upward, with wrap, from the thread after the most recently issued one.
- R6: When no thread is eligible, `issue_vld_o` is low, and `issue_tid_o` and `issue_pc_o` are zero.
- R7: A thread that issues with its `last_i` bit high is finished. It is never issued again, whatever its `avail_i` input or any completion does.
- R8: If a completion names a thread in the same clock in which that thread issues a load, the thread ends up waiting.
- R9: Each issue advances the issuing thread's program counter by 4, modulo 2^16. The counters of other threads do not change.
- R10: A completion for a waiting thread makes that thread eligible in the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| avail_i | input | 4 | Per-thread: an instruction is ready to issue |
| load_i | input | 4 | Per-thread: the offered instruction is a long-latency load |
| last_i | input | 4 | Per-thread: the offered instruction ends the thread |
| cmpl_vld_i | input | 1 | A load has completed |
| cmpl_tid_i | input | 2 | Thread number of the completed load |
| issue_vld_o | output | 1 | An instruction issues this clock |
| issue_tid_o | output | 2 | Thread that issues |
| issue_pc_o | output | 16 | Program counter of the issued instruction |

## Verification
If the wait flag of a context is wrong, the fault shows up at the first clock in which that thread offers an instruction. Either the thread issues while a load is still outstanding, or it is skipped while it should be eligible, and in both cases the grant order or the valid flag changes at once. A wrong rotation pointer or a wrong program counter shows up in the next `issue_tid_o` or `issue_pc_o` value. A finished flag that is lost shows up the next time that thread offers work. Because the bench keeps every thread offering work in most cycles, each such fault reaches the ports within one to four clocks.

// File: rtl/mtis_pkg.sv
package mtis_pkg;
  // per-context status flags
  typedef struct packed {
    logic waiting;   // long-latency load outstanding
    logic finished;  // thread retired, never selected again
  } ctx_flags_t;
endpackage

// File: rtl/mtis_ctx.sv
// One hardware thread context: program counter plus status flags.
module mtis_ctx
  import mtis_pkg::*;
#(
  parameter int              PC_W    = 16,
  parameter logic [PC_W-1:0] PC_BASE = '0,
  parameter int              PC_STEP = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,       // this context holds the issue slot
  input  logic            sel_load_i,  // issued instruction is a load
  input  logic            sel_last_i,  // issued instruction ends the thread
  input  logic            wake_i,      // load completion addressed here
  output logic [PC_W-1:0] pc_o,
  output ctx_flags_t      flags_o
);

  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  logic [PC_W-1:0] pc_q, pc_d;
  ctx_flags_t      flags_q, flags_d;
  logic            pc_en, flags_en;

  always_comb begin
    pc_d     = pc_q + STEP;
    pc_en    = sel_i;
    flags_d  = flags_q;
    if (wake_i) begin
      flags_d.waiting = 1'b0;
    end
    // a new stall wins over a completion in the same clock
    if (sel_i && sel_load_i) begin
      flags_d.waiting = 1'b1;
    end
    if (sel_i && sel_last_i) begin
      flags_d.finished = 1'b1;
    end
    flags_en = wake_i | sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= PC_BASE;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  assign pc_o    = pc_q;
  assign flags_o = flags_q;

endmodule

// File: rtl/mtis_rr_pick.sv
// Rotating picker: first requester after the most recent grant.
module mtis_rr_pick #(
  parameter int NUM_THR = 4,
  parameter int TID_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_THR-1:0] req_i,
  output logic               gnt_vld_o,
  output logic [TID_W-1:0]   gnt_id_o
);

  localparam logic [TID_W-1:0] LAST_RST = TID_W'(NUM_THR - 1);

  logic [TID_W-1:0] last_q, last_d;
  logic             last_en;
  logic             found;
  logic [TID_W-1:0] pick;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NUM_THR; k++) begin
      automatic int idx = (int'(last_q) + k) % NUM_THR;
      if (!found && req_i[idx]) begin
        found = 1'b1;
        pick  = TID_W'(idx);
      end
    end
    last_d  = pick;
    last_en = found;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= LAST_RST;
    end else if (last_en) begin
      last_q <= last_d;
    end
  end

  assign gnt_vld_o = found;
  assign gnt_id_o  = pick;

endmodule

// File: rtl/mt_issue_sched.sv
// Issue scheduler for a single-issue core with several thread contexts.
module mt_issue_sched
  import mtis_pkg::*;
#(
  parameter int NUM_THR = 4,
  parameter int PC_W    = 16,
  parameter int PC_SPAN = 'h400,
  parameter int PC_STEP = 4,
  parameter int TID_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_THR-1:0] avail_i,
  input  logic [NUM_THR-1:0] load_i,
  input  logic [NUM_THR-1:0] last_i,
  input  logic               cmpl_vld_i,
  input  logic [TID_W-1:0]   cmpl_tid_i,
  output logic               issue_vld_o,
  output logic [TID_W-1:0]   issue_tid_o,
  output logic [PC_W-1:0]    issue_pc_o
);

  logic [NUM_THR-1:0] stall_mask;
  logic [NUM_THR-1:0] done_mask;
  logic [NUM_THR-1:0] eligible;
  logic [NUM_THR-1:0] sel_vec;
  logic [NUM_THR-1:0] wake_vec;
  logic [PC_W-1:0]    pc_arr [NUM_THR];
  logic               gnt_vld;
  logic [TID_W-1:0]   gnt_id;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_ctx
    ctx_flags_t flags;

    assign sel_vec[t]  = gnt_vld && (gnt_id == TID_W'(t));
    assign wake_vec[t] = cmpl_vld_i && (cmpl_tid_i == TID_W'(t));

    mtis_ctx #(
      .PC_W    (PC_W),
      .PC_BASE (PC_W'(t * PC_SPAN)),
      .PC_STEP (PC_STEP)
    ) u_ctx (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sel_i      (sel_vec[t]),
      .sel_load_i (load_i[t]),
      .sel_last_i (last_i[t]),
      .wake_i     (wake_vec[t]),
      .pc_o       (pc_arr[t]),
      .flags_o    (flags)
    );

    assign stall_mask[t] = flags.waiting;
    assign done_mask[t]  = flags.finished;
    assign eligible[t]   = avail_i[t] & ~flags.waiting & ~flags.finished;
  end

  mtis_rr_pick #(
    .NUM_THR (NUM_THR),
    .TID_W   (TID_W)
  ) u_pick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (eligible),
    .gnt_vld_o (gnt_vld),
    .gnt_id_o  (gnt_id)
  );

  always_comb begin
    issue_vld_o = gnt_vld;
    issue_tid_o = gnt_vld ? gnt_id : '0;
    issue_pc_o  = gnt_vld ? pc_arr[gnt_id] : '0;
  end

endmodule

// File: rtl/mtis_sva.sv
// Property checker for the issue scheduler, attached by bind.
module mtis_sva #(
  parameter int NUM_THR = 4,
  parameter int TID_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_THR-1:0] avail,
  input logic [NUM_THR-1:0] load,
  input logic [NUM_THR-1:0] last,
  input logic               cmpl_vld,
  input logic [TID_W-1:0]   cmpl_tid,
  input logic               issue_vld,
  input logic [TID_W-1:0]   issue_tid,
  input logic [NUM_THR-1:0] stall_mask,
  input logic [NUM_THR-1:0] done_mask
);

  // R2: grant only to a thread that offers an instruction
  a_r2_grant_offered: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> avail[issue_tid]);

  // R3: a waiting thread never holds the slot
  a_r3_no_waiting_issue: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> !stall_mask[issue_tid]);

  // R4: work-conserving whenever someone is eligible
  a_r4_slot_used: assert property (@(posedge clk) disable iff (!rst_n)
    (|(avail & ~stall_mask & ~done_mask)) |-> issue_vld);

  // R6: nothing offered, nothing issued
  a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (avail == '0) |-> !issue_vld);

  // R7: finished threads stay finished and never issue
  a_r7_no_done_issue: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> !done_mask[issue_tid]);
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_mask != '0) |=> ((done_mask & $past(done_mask)) == $past(done_mask)));
  a_r7_last_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && last[issue_tid]) |=> done_mask[$past(issue_tid)]);

  // R8: an issued load leaves its thread waiting, completion or not
  a_r8_load_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && load[issue_tid]) |=> stall_mask[$past(issue_tid)]);

  // R10: completion for a waiting thread that is not issuing clears it
  a_r10_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_vld && stall_mask[cmpl_tid]) |=> !stall_mask[$past(cmpl_tid)]);

endmodule

bind mt_issue_sched mtis_sva #(
  .NUM_THR (NUM_THR),
  .TID_W   (TID_W)
) u_sva (
  .clk        (clk_i),
  .rst_n      (rst_ni),
  .avail      (avail_i),
  .load       (load_i),
  .last       (last_i),
  .cmpl_vld   (cmpl_vld_i),
  .cmpl_tid   (cmpl_tid_i),
  .issue_vld  (issue_vld_o),
  .issue_tid  (issue_tid_o),
  .stall_mask (stall_mask),
  .done_mask  (done_mask)
);

// File: tb/tb_mt_issue_sched.sv
`timescale 1ns/1ps
module tb_mt_issue_sched;

  localparam int N    = 4;
  localparam int TW   = 2;
  localparam int PW   = 16;
  localparam int SPAN = 'h400;
  localparam int STEP = 4;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  avail, load, last;
  logic          cvld;
  logic [TW-1:0] ctid;
  logic          ivld;
  logic [TW-1:0] itid;
  logic [PW-1:0] ipc;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic          vld;
    logic [TW-1:0] tid;
    logic [PW-1:0] pc;
    string         req;
  } exp_t;
  exp_t sb[$];

  // reference state built from the requirements
  logic [PW-1:0] m_pc [N];
  logic [N-1:0]  m_wait, m_fin;
  int            m_last;

  mt_issue_sched dut (
    .clk_i(clk), .rst_ni(rst_n), .avail_i(avail), .load_i(load), .last_i(last),
    .cmpl_vld_i(cvld), .cmpl_tid_i(ctid),
    .issue_vld_o(ivld), .issue_tid_o(itid), .issue_pc_o(ipc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic compare(exp_t e);
    checks++;
    if (ivld !== e.vld || itid !== e.tid || ipc !== e.pc) begin
      errors++;
      $display("FAIL %s: got vld=%0b tid=%0d pc=%h, expected vld=%0b tid=%0d pc=%h",
               e.req, ivld, itid, ipc, e.vld, e.tid, e.pc);
    end
  endtask

  // monitor: pops one expectation per clock, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) compare(sb.pop_front());
    end
  end

  task automatic model_reset();
    for (int t = 0; t < N; t++) m_pc[t] = PW'(t * SPAN);
    m_wait = '0;
    m_fin  = '0;
    m_last = N - 1;
  endtask

  // driver: applies one clock of stimulus and queues the expected result
  task automatic step(input logic [N-1:0] a, input logic [N-1:0] ld,
                      input logic [N-1:0] ls, input logic cv, input int ct,
                      input string req);
    exp_t e;
    logic [N-1:0] elig;
    @(posedge clk);
    #1;
    avail = a; load = ld; last = ls; cvld = cv; ctid = TW'(ct);
    elig  = a & ~m_wait & ~m_fin;
    e.vld = 1'b0; e.tid = '0; e.pc = '0; e.req = req;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (m_last + k) % N;
      if (!e.vld && elig[idx]) begin
        e.vld = 1'b1; e.tid = TW'(idx); e.pc = m_pc[idx];
      end
    end
    sb.push_back(e);
    if (cv) m_wait[ct] = 1'b0;
    if (e.vld) begin
      m_pc[e.tid] = m_pc[e.tid] + PW'(STEP);
      if (ld[e.tid]) m_wait[e.tid] = 1'b1;
      if (ls[e.tid]) m_fin[e.tid] = 1'b1;
      m_last = int'(e.tid);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    exp_t r;
    rst_n = 1'b0;
    avail = '0; load = '0; last = '0; cvld = 1'b0; ctid = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    r.vld = 1'b0; r.tid = '0; r.pc = '0; r.req = "R1 reset";
    compare(r);
    @(posedge clk); #1 rst_n = 1'b1;

    // R6: nothing offered after reset
    step(4'b0000, 4'b0000, 4'b0000, 1'b0, 0, "R6 idle");
    // R1, R5, R9: full rotation from thread 0 with base PCs
    for (int i = 0; i < 6; i++) step(4'b1111, 4'b0000, 4'b0000, 1'b0, 0, "R1 R5 R9 rotate");
    // R2: only one thread offers
    step(4'b0100, 4'b0000, 4'b0000, 1'b0, 0, "R2 single offer");
    step(4'b0100, 4'b0000, 4'b0000, 1'b0, 0, "R2 single offer");
    step(4'b1001, 4'b0000, 4'b0000, 1'b0, 0, "R5 wrap search");
    // R3, R4: thread 0 gets a load; others keep the slot busy
    step(4'b0001, 4'b0001, 4'b0000, 1'b0, 0, "R3 issue load");
    for (int i = 0; i < 5; i++) step(4'b1111, 4'b0000, 4'b0000, 1'b0, 0, "R3 R4 skip waiting");
    // R3: completion for another thread keeps thread 0 waiting
    step(4'b0001, 4'b0000, 4'b0000, 1'b1, 2, "R3 foreign completion");
    step(4'b0001, 4'b0000, 4'b0000, 1'b0, 0, "R3 still waiting");
    // R10: real completion, eligible next clock
    step(4'b0001, 4'b0000, 4'b0000, 1'b1, 0, "R10 completion cycle");
    step(4'b0001, 4'b0000, 4'b0000, 1'b0, 0, "R10 wake next clock");
    // R6: every thread waits on a load
    for (int i = 0; i < 4; i++) step(4'b1111, 4'b1111, 4'b0000, 1'b0, 0, "R3 all load");
    step(4'b1111, 4'b0000, 4'b0000, 1'b0, 0, "R6 all waiting");
    // R4 R10: wake thread 2 then thread 1
    step(4'b1111, 4'b0000, 4'b0000, 1'b1, 2, "R6 completion cycle");
    step(4'b1111, 4'b0000, 4'b0000, 1'b1, 1, "R10 wake 2");
    step(4'b1111, 4'b0000, 4'b0000, 1'b0, 0, "R4 R5 after wake");
    step(4'b1111, 4'b0000, 4'b0000, 1'b0, 0, "R4 R5 after wake");
    // R8: completion for thread 1 in the clock it issues a load
    step(4'b0010, 4'b0010, 4'b0000, 1'b1, 1, "R8 collide");
    step(4'b0110, 4'b0000, 4'b0000, 1'b0, 0, "R8 stays waiting");
    step(4'b0010, 4'b0000, 4'b0000, 1'b0, 0, "R8 stays waiting");
    step(4'b0010, 4'b0000, 4'b0000, 1'b1, 1, "R10 wake 1");
    step(4'b0010, 4'b0000, 4'b0000, 1'b0, 0, "R10 wake 1 next");
    // R7: thread 2 finishes; offers and completions do not revive it
    step(4'b0100, 4'b0000, 4'b0100, 1'b0, 0, "R7 retire");
    step(4'b0100, 4'b0000, 4'b0000, 1'b1, 2, "R7 completion ignored");
    step(4'b0100, 4'b0000, 4'b0000, 1'b0, 0, "R7 finished silent");
    for (int i = 0; i < 4; i++) step(4'b1111, 4'b0000, 4'b0000, 1'b0, 0, "R7 R5 skip finished");
    // R9: long run on thread 3 for counter progress
    for (int i = 0; i < 20; i++) step(4'b1000, 4'b0000, 4'b0000, 1'b0, 0, "R9 pc advance");
    step(4'b0000, 4'b0000, 4'b0000, 1'b0, 0, "R6 idle end");

    @(negedge clk);
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule